// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that behaves as a 256-by-8 byte-addressable serial EEPROM. It runs on a fast system clock. It brings the bus clock and data lines in through a synchronizer chain and drives the data line only by pulling it low through an open-drain enable. The block recognises Start, repeated Start and Stop conditions. It answers a fixed 7-bit device address and holds its storage in an internal register array.

A host stores a byte by sending the control byte with the write direction, a word address and one data byte, then a Stop. The Stop commits the byte and starts a self-timed write cycle. Until that cycle ends, the target ignores its own address, so the host can poll for completion. One internal pointer serves all read modes: a current-address read, a random read (word address followed by a repeated Start) and sequential reads that run on while the host keeps acknowledging. After every byte transferred, the pointer moves on by one and wraps from the top of the array to zero.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The target acknowledges a control byte only when its upper seven bits equal the device address 7'b1010000. For any other address it does not acknowledge, and it ignores every bus bit until the next Start.
- R2: A control byte with direction bit 0 is acknowledged when the target is idle. The word address byte that follows is acknowledged and loads the pointer.
- R3: The first data byte of a write is acknowledged, and the following Stop writes it at the pointer address. After the write, the pointer holds that address plus one.
- R4: The Stop that commits a write starts a busy period of WR_CYCLES system clocks. During this period no control byte is acknowledged; once it ends, control bytes are acknowledged again.
- R5: A control byte with direction bit 1 is acknowledged, and the target then shifts out the byte at the pointer, most significant bit first, one bit per SCL low phase.
- R6: A current-address read after an access to address n returns the byte at n+1.
- R7: For a random read, the pointer takes the written word address even though a repeated Start follows without data. After the read, the pointer addresses the next location.
- R8: While the host acknowledges each read byte, the target sends the byte at the next address, and the pointer wraps from 8'hFF to 8'h00.
- R9: After the host does not acknowledge a read byte, the target releases SDA and stays released through the Stop.
- R10: A Stop in the middle of a byte aborts the transfer without writing and without starting a busy period. A repeated Start after a data byte discards that byte.
- R11: Data bytes after the first one in a write are not acknowledged and are not stored.
- R12: After reset, SDA is released, the pointer is 0 and every memory byte reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sensed at the pin |
| sda_i | input | 1 | Bus data line as sensed at the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases the line |

## Verification
The bench builds the target with WR_CYCLES = 2000, two synchronizer stages, a cleared array on reset and an SCL period of 40 system clocks. With these values, a busy period spans several complete control-byte polls: the first poll after a Stop is always refused, and a later poll is accepted within a bounded number of tries. The cleared array makes unwritten locations read back as zero, so aborted, discarded and surplus writes can be shown to have left no trace. Pointer wrap, the shared pointer across the three read modes, and aborts both in the middle of a byte and after a byte are each driven by their own scenario.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CTRL,
      ST_CACK,
      ST_WADR,
      ST_AACK,
      ST_WDAT,
      ST_DACK,
      ST_RDAT,
      ST_RACK
   } ee_state_t;
endpackage

// File: rtl/i2c_ee_linesync.sv
module i2c_ee_linesync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det,
   output logic sda_lvl
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_ee_linesync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_sh, sda_sh;
   logic scl_q, sda_q, scl_s, sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[STAGES-2:0], sda_i};
         scl_q  <= scl_sh[STAGES-1];
         sda_q  <= sda_sh[STAGES-1];
      end
   end

   assign scl_s     = scl_sh[STAGES-1];
   assign sda_s     = sda_sh[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
   assign sda_lvl   = sda_s;
endmodule

// File: rtl/i2c_ee_array.sv
module i2c_ee_array #(
   parameter int AW             = 8,
   parameter int DW             = 8,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   generate
      if (AW < 1 || AW > 12) begin : g_bad_aw
         $error("i2c_ee_array: AW out of range");
      end
   endgenerate

   logic [DW-1:0] cells [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
            end else if (we) begin
               cells[waddr] <= wdata;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we) cells[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata = cells[raddr];
endmodule

// File: rtl/i2c_ee_wrtimer.sv
module i2c_ee_wrtimer #(
   parameter int unsigned CYCLES = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   output logic busy
);
   localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;

   generate
      if (CYCLES < 2) begin : g_bad_cycles
         $error("i2c_ee_wrtimer: CYCLES must be at least 2");
      end
   endgenerate

   logic [CW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         left <= '0;
      end else if (kick) begin
         busy <= 1'b1;
         left <= CW'(CYCLES - 1);
      end else if (busy) begin
         if (left == '0) busy <= 1'b0;
         else            left <= left - 1'b1;
      end
   end
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
   import i2c_ee_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR       = 7'b1010000,
   parameter int          ADDR_W         = 8,
   parameter int          DATA_W         = 8,
   parameter int unsigned WR_CYCLES      = 5000,
   parameter int          SYNC_STAGES    = 2,
   parameter bit          CLEAR_ON_RESET = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

   generate
      if (DATA_W != 8) begin : g_bad_dw
         $error("i2c_eeprom_target: bus bytes are 8 bits wide");
      end
      if (ADDR_W > DATA_W) begin : g_bad_aw
         $error("i2c_eeprom_target: word address must fit one byte");
      end
   endgenerate

   logic scl_rise, scl_fall, start_det, stop_det, sda_lvl;
   logic busy, mem_we, ld;
   logic [DATA_W-1:0] rdata;

   ee_state_t         state;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] shreg, txreg, wbuf;
   logic [ADDR_W-1:0] ptr;
   logic              wr_pend, ack_drv, rw_bit, host_ack;

   i2c_ee_linesync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_lvl   (sda_lvl)
   );

   i2c_ee_wrtimer #(.CYCLES(WR_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .kick  (mem_we),
      .busy  (busy)
   );

   i2c_ee_array #(
      .AW             (ADDR_W),
      .DW             (DATA_W),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_array (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we),
      .waddr (ptr),
      .wdata (wbuf),
      .raddr (ptr),
      .rdata (rdata)
   );

   assign mem_we = stop_det & wr_pend;
   assign ld     = scl_fall & (((state == ST_CACK) & rw_bit) |
                               ((state == ST_RACK) & host_ack));

   always_comb begin
      case (state)
         ST_CACK, ST_AACK, ST_DACK: sda_oe = ack_drv;
         ST_RDAT:                   sda_oe = ~txreg[DATA_W-1];
         default:                   sda_oe = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         shreg    <= '0;
         txreg    <= '0;
         wbuf     <= '0;
         ptr      <= '0;
         wr_pend  <= 1'b0;
         ack_drv  <= 1'b0;
         rw_bit   <= 1'b0;
         host_ack <= 1'b0;
      end else if (start_det) begin
         state   <= ST_CTRL;
         cnt     <= '0;
         wr_pend <= 1'b0;
         ack_drv <= 1'b0;
      end else if (stop_det) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         wr_pend <= 1'b0;
         ack_drv <= 1'b0;
         if (wr_pend) ptr <= ptr + 1'b1;
      end else begin
         if (ld) begin
            txreg <= rdata;
            ptr   <= ptr + 1'b1;
            cnt   <= '0;
            state <= ST_RDAT;
         end
         case (state)
            ST_CTRL, ST_WADR, ST_WDAT: begin
               if (scl_rise) begin
                  shreg <= {shreg[DATA_W-2:0], sda_lvl};
                  cnt   <= cnt + 1'b1;
               end else if (scl_fall && cnt == LAST_BIT) begin
                  cnt <= '0;
                  if (state == ST_CTRL) begin
                     if (shreg[DATA_W-1:1] == DEV_ADDR && !busy) begin
                        ack_drv <= 1'b1;
                        rw_bit  <= shreg[0];
                        state   <= ST_CACK;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else if (state == ST_WADR) begin
                     ptr     <= shreg[ADDR_W-1:0];
                     ack_drv <= 1'b1;
                     state   <= ST_AACK;
                  end else begin
                     wbuf    <= shreg;
                     wr_pend <= 1'b1;
                     ack_drv <= 1'b1;
                     state   <= ST_DACK;
                  end
               end
            end
            ST_CACK: begin
               if (scl_fall) begin
                  ack_drv <= 1'b0;
                  if (!rw_bit) state <= ST_WADR;
               end
            end
            ST_AACK: begin
               if (scl_fall) begin
                  ack_drv <= 1'b0;
                  state   <= ST_WDAT;
               end
            end
            ST_DACK: begin
               if (scl_fall) begin
                  ack_drv <= 1'b0;
                  state   <= ST_IDLE;
               end
            end
            ST_RDAT: begin
               if (scl_rise) begin
                  cnt <= cnt + 1'b1;
               end else if (scl_fall) begin
                  if (cnt == LAST_BIT) begin
                     cnt   <= '0;
                     state <= ST_RACK;
                  end else begin
                     txreg <= {txreg[DATA_W-2:0], 1'b0};
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) host_ack <= ~sda_lvl;
               else if (scl_fall && !host_ack) state <= ST_IDLE;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/i2c_ee_checker.sv
module i2c_ee_checker
   import i2c_ee_pkg::*;
#(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input ee_state_t     state,
   input logic [AW-1:0] ptr,
   input logic          busy,
   input logic          stop_det,
   input logic          ld,
   input logic          mem_we,
   input logic          ack_drv,
   input logic          sda_oe
);
   // R4
   busy_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_det));

   // R4
   no_ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CACK) |-> !(busy && ack_drv));

   // R8
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (ptr == AW'($past(ptr) + 1'b1)));

   // R3
   commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> busy);

   // R9
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);
endmodule

bind i2c_eeprom_target i2c_ee_checker #(.AW(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .state    (state),
   .ptr      (ptr),
   .busy     (busy),
   .stop_det (stop_det),
   .ld       (ld),
   .mem_we   (mem_we),
   .ack_drv  (ack_drv),
   .sda_oe   (sda_oe)
);

// File: tb/sim_i2c_eeprom_target.sv
`timescale 1ns/1ps
module sim_i2c_eeprom_target;
   localparam int Q = 10;
   localparam logic [7:0] CW = 8'hA0;
   localparam logic [7:0] CR = 8'hA1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_h = 1'b1;
   logic sda_h = 1'b1;
   logic sda_oe;
   logic sda_bus;
   int   errors = 0;
   int   checks = 0;

   always #2 clk = ~clk;
   assign sda_bus = sda_h & ~sda_oe;

   i2c_eeprom_target #(
      .WR_CYCLES      (2000),
      .SYNC_STAGES    (2),
      .CLEAR_ON_RESET (1'b1)
   ) u0 (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_i  (scl_h),
      .sda_i  (sda_bus),
      .sda_oe (sda_oe)
   );

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic h_start;
      sda_h = 1'b1; wq(Q);
      scl_h = 1'b1; wq(Q);
      sda_h = 1'b0; wq(Q);
      scl_h = 1'b0; wq(Q);
   endtask

   task automatic h_stop;
      sda_h = 1'b0; wq(Q);
      scl_h = 1'b1; wq(Q);
      sda_h = 1'b1; wq(Q);
   endtask

   task automatic h_bit(input logic b);
      sda_h = b;    wq(Q);
      scl_h = 1'b1; wq(2*Q);
      scl_h = 1'b0; wq(Q);
   endtask

   task automatic h_sample(output logic b);
      sda_h = 1'b1; wq(Q);
      scl_h = 1'b1; wq(Q);
      b = sda_bus;  wq(Q);
      scl_h = 1'b0; wq(Q);
   endtask

   task automatic h_wr(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) h_bit(v[i]);
      h_sample(b);
      ack = ~b;
   endtask

   task automatic h_rd(input logic give_ack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         h_sample(b);
         v[i] = b;
      end
      h_bit(~give_ack);
   endtask

   task automatic poll_ready(output int polls);
      logic a;
      polls = 0;
      a = 1'b0;
      while (!a && polls < 40) begin
         h_start;
         h_wr(CW, a);
         polls++;
      end
      h_stop;
   endtask

   task automatic store(input logic [7:0] adr, input logic [7:0] d, input string req);
      logic a;
      int   p;
      h_start;
      h_wr(CW, a);  chk({req, " ctrl ack"}, a, 1'b1);
      h_wr(adr, a); chk({req, " addr ack"}, a, 1'b1);
      h_wr(d, a);   chk({req, " data ack"}, a, 1'b1);
      h_stop;
      poll_ready(p);
   endtask

   task automatic t_reset;
      chk("R12 sda released after reset", sda_oe, 1'b0);
   endtask

   task automatic t_cur_read_reset;
      logic a;
      logic [7:0] v;
      h_start;
      h_wr(CR, a);  chk("R5 read ctrl ack", a, 1'b1);
      h_rd(1'b0, v); chk("R12 cleared byte at pointer 0", v, 8'h00);
      h_stop;
   endtask

   task automatic t_bad_addr;
      logic a;
      h_start;
      h_wr(8'hA2, a); chk("R1 wrong address nack", a, 1'b0);
      h_wr(CW, a);    chk("R1 ignored until next start", a, 1'b0);
      h_stop;
      h_start;
      h_wr(CW, a);    chk("R1 own address ack after start", a, 1'b1);
      h_stop;
   endtask

   task automatic t_byte_write;
      logic a;
      logic [7:0] v;
      int p;
      store(8'h11, 8'hC3, "R2");
      h_start;
      h_wr(CW, a);    chk("R2 ctrl ack", a, 1'b1);
      h_wr(8'h10, a); chk("R2 word addr ack", a, 1'b1);
      h_wr(8'h5A, a); chk("R3 data ack", a, 1'b1);
      h_stop;
      h_start;
      h_wr(CW, a);    chk("R4 first poll refused", a, 1'b0);
      poll_ready(p);
      chk("R4 accepted after busy window", (p >= 1 && p <= 8), 1'b1);
      h_start;
      h_wr(CR, a);    chk("R5 ctrl ack", a, 1'b1);
      h_rd(1'b0, v);  chk("R6 current read returns n+1 byte", v, 8'hC3);
      h_stop;
   endtask

   task automatic t_random_read;
      logic a;
      logic [7:0] v;
      h_start;
      h_wr(CW, a);    chk("R7 ctrl ack", a, 1'b1);
      h_wr(8'h10, a); chk("R7 addr ack", a, 1'b1);
      h_start;
      h_wr(CR, a);    chk("R7 read ctrl ack", a, 1'b1);
      h_rd(1'b0, v);  chk("R3 R7 random read byte", v, 8'h5A);
      h_stop;
      h_start;
      h_wr(CR, a);
      h_rd(1'b0, v);  chk("R7 pointer follows read", v, 8'hC3);
      h_stop;
   endtask

   task automatic t_seq_wrap;
      logic a;
      logic [7:0] v;
      store(8'hFE, 8'h11, "R8");
      store(8'hFF, 8'h22, "R8");
      store(8'h00, 8'h33, "R8");
      h_start;
      h_wr(CW, a);
      h_wr(8'hFE, a);
      h_start;
      h_wr(CR, a);    chk("R8 read ctrl ack", a, 1'b1);
      h_rd(1'b1, v);  chk("R8 seq byte FE", v, 8'h11);
      h_rd(1'b1, v);  chk("R8 seq byte FF", v, 8'h22);
      h_rd(1'b0, v);  chk("R8 wrap to 00", v, 8'h33);
      chk("R9 released after host nack", sda_oe, 1'b0);
      h_stop;
      chk("R9 released after stop", sda_oe, 1'b0);
      h_start;
      h_wr(CR, a);
      h_rd(1'b0, v);  chk("R8 pointer after wrap", v, 8'h00);
      h_stop;
   endtask

   task automatic t_abort;
      logic a;
      logic [7:0] v;
      h_start;
      h_wr(CW, a);
      h_wr(8'h40, a);
      h_bit(1'b1); h_bit(1'b0); h_bit(1'b1); h_bit(1'b0);
      h_stop;
      h_start;
      h_wr(CW, a);    chk("R10 no busy after mid-byte stop", a, 1'b1);
      h_wr(8'h40, a);
      h_start;
      h_wr(CR, a);
      h_rd(1'b0, v);  chk("R10 aborted byte not stored", v, 8'h00);
      h_stop;
      h_start;
      h_wr(CW, a);
      h_wr(8'h41, a);
      h_wr(8'h77, a);
      h_start;
      h_wr(CR, a);    chk("R10 no busy after repeated start", a, 1'b1);
      h_rd(1'b0, v);  chk("R10 discarded byte not stored", v, 8'h00);
      h_stop;
   endtask

   task automatic t_extra_byte;
      logic a;
      logic [7:0] v;
      int p;
      h_start;
      h_wr(CW, a);
      h_wr(8'h50, a);
      h_wr(8'hAB, a); chk("R11 first data ack", a, 1'b1);
      h_wr(8'hCD, a); chk("R11 second data nack", a, 1'b0);
      h_stop;
      poll_ready(p);
      h_start;
      h_wr(CW, a);
      h_wr(8'h50, a);
      h_start;
      h_wr(CR, a);
      h_rd(1'b1, v);  chk("R11 first byte stored", v, 8'hAB);
      h_rd(1'b0, v);  chk("R11 surplus byte dropped", v, 8'h00);
      h_stop;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog all requirements actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      wq(5);
      rst_n = 1'b1;
      wq(5);
      t_reset;
      t_cur_read_reset;
      t_bad_addr;
      t_byte_write;
      t_random_read;
      t_seq_wrap;
      t_abort;
      t_extra_byte;
      wq(20);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule